// File: doc/BRIEF.md
# Virtual Channel Mapping Programmer

This block sets up the virtual-channel resources on one end of a point-to-point link. It handles four fixed channels: a primary channel, a secondary channel, a private channel and a management channel. A pulse on `start_i` captures an 8-bit traffic-class bitmap and an enable flag for each channel. The block then confirms that every traffic class belongs to exactly one enabled channel. If that check passes, it writes the channel control words through a simple register master port and updates the extended channel count. It then polls each channel's status until negotiation completes and finally locks the configuration.

The register port uses a single-outstanding request/acknowledge handshake. Software-visible state lives in the register slave. The block only sequences accesses and uses read-modify-write wherever it must keep bits it does not own. Once the lock has been written, the block does no further register accesses until reset. A failed mapping check or a negotiation that never finishes is reported on `err_o`.

Top module: `vcmap_prog`

## Requirements
- R1: Each control word has the channel enable in bit 31, the 3-bit channel ID in bits 26:24 (IDs 0, 1, 2 and 7 for the primary, secondary, private and management channels), the class bitmap in bits 7:0, and zeros elsewhere.
- R2: A disabled channel claims no class. If any of the 8 classes is claimed by two or more enabled channels, or by none, the block raises `err_o` and pulses `done_o` without making any register access.
- R3: The configuration register (address 0x0040) is read and then written back. The write keeps the unrelated bits, sets bits 23:20 to 2, and sets bits 19 and 17 only when the private channel is enabled.
- R4: Control words are written in the order primary, secondary, private, management. Channel c has its control register at 0x0100 + 0x10*c and its status register at 0x0108 + 0x10*c.
- R5: The capability register (address 0x0008) is read and written back with bits 2:0 equal to the secondary channel's enable and all other bits kept.
- R6: Each status register is read repeatedly until bit 1 (negotiation pending) reads 0. Channels are polled in the order primary, secondary, private, management, so a channel reporting pending N times is read N+1 times.
- R7: If a channel is still pending after POLL_LIMIT reads (default 16), the block raises `err_o`, pulses `done_o`, stops polling and does not write the lock.
- R8: After all four channels report not pending, the configuration register is written once more with bit 31 set. This lock is the last access, and a successful run makes exactly 7 writes.
- R9: Once locked, a later `start_i` pulses `done_o` and makes no register access until reset.
- R10: After reset, `done_o`, `err_o` and `reg_req_o` are 0. `done_o` is a one-cycle pulse. `err_o` holds until the next accepted `start_i`.
- R11: `reg_req_o`, `reg_we_o` and `reg_addr_o` stay stable from request until the cycle `reg_ack_i` is seen, then `reg_req_o` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a programming run |
| tc_map_i | input | 32 | Class bitmaps, channel c in bits 8c+7:8c |
| ch_act_i | input | 4 | Channel enables, bit c for channel c |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Mapping or negotiation failure |
| reg_req_o | output | 1 | Register access request |
| reg_we_o | output | 1 | 1 for write, 0 for read |
| reg_addr_o | output | 16 | Register address |
| reg_wdata_o | output | 32 | Write data |
| reg_rdata_i | input | 32 | Read data, valid with acknowledge |
| reg_ack_i | input | 1 | Access acknowledge |

## Verification
The hardest case to reach is a poll timeout part-way through negotiation, because it only happens when one channel keeps reporting pending after the earlier channels have already cleared. The bench's register slave model is given a per-channel count of pending replies. Setting the private channel's count above the poll limit produces a run that has written every control word but stops short of the lock. Other vectors set nonzero counts that clear before the limit, so the polling order and the read count per channel can be checked.

// File: rtl/vcmap_pkg.sv
package vcmap_pkg;
  localparam int NUM_CH  = 4;
  localparam int TC_W    = 8;
  localparam int ID_W    = 3;

  localparam int CTL_EN_BIT    = 31;
  localparam int CTL_ID_LSB    = 24;
  localparam int STS_PEND_BIT  = 1;
  localparam int CFG_LOCK_BIT  = 31;
  localparam int CFG_FLD_LSB   = 20;
  localparam int CFG_FLD_W     = 4;
  localparam int CFG_FLD_VAL   = 2;
  localparam int CFG_PRIV_A    = 19;
  localparam int CFG_PRIV_B    = 17;
  localparam int CAP_CNT_W     = 3;
  localparam int PRIV_CH       = 2;
  localparam int SEC_CH        = 1;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHECK,
    ST_CFG_RD,
    ST_CFG_WR,
    ST_CTL_WR,
    ST_CAP_RD,
    ST_CAP_WR,
    ST_POLL,
    ST_LOCK
  } seq_state_t;
endpackage

// File: rtl/vcmap_check.sv
module vcmap_check #(
  parameter int                            NCH  = vcmap_pkg::NUM_CH,
  parameter int                            TCW  = vcmap_pkg::TC_W,
  parameter int                            IDW  = vcmap_pkg::ID_W,
  parameter logic [vcmap_pkg::NUM_CH*vcmap_pkg::ID_W-1:0] IDS = {3'd7, 3'd2, 3'd1, 3'd0}
) (
  input  logic [NCH*TCW-1:0] maps_i,
  input  logic [NCH-1:0]     act_i,
  output logic               ok_o,
  output logic [NCH*32-1:0]  words_o
);
  import vcmap_pkg::*;

  logic [TCW-1:0] tc_single;

  // One claim count per traffic class; exactly one enabled owner required (R2)
  for (genvar t = 0; t < TCW; t++) begin : g_tc
    logic [NCH-1:0] claim;
    for (genvar c = 0; c < NCH; c++) begin : g_claim
      assign claim[c] = act_i[c] & maps_i[c*TCW + t];
    end
    assign tc_single[t] = ($countones(claim) == 1);
  end

  assign ok_o = &tc_single;

  // Control word assembly per channel (R1)
  for (genvar c = 0; c < NCH; c++) begin : g_word
    logic [31:0] w;
    always_comb begin
      w = '0;
      w[CTL_EN_BIT] = act_i[c];
      w[CTL_ID_LSB +: IDW] = IDS[c*IDW +: IDW];
      w[TCW-1:0] = maps_i[c*TCW +: TCW];
    end
    assign words_o[c*32 +: 32] = w;
  end
endmodule

// File: rtl/vcmap_bus.sv
module vcmap_bus #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          fin_o,
  output logic [DW-1:0] rdata_o,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  input  logic [DW-1:0] rdata_i,
  input  logic          ack_i
);
  logic          req_q, we_q, fin_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      fin_q   <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (go_i && !req_q) begin
        req_q   <= 1'b1;
        we_q    <= we_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end else if (req_q && ack_i) begin
        req_q   <= 1'b0;
        rdata_q <= rdata_i;
        fin_q   <= 1'b1;
      end
    end
  end

  assign req_o   = req_q;
  assign we_o    = we_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign fin_o   = fin_q;
  assign rdata_o = rdata_q;

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (req_q && !ack_i) |=> (req_q && $stable(addr_q) && $stable(we_q)));

  assert_req_drop_R11: assert property (@(posedge clk) disable iff (rst)
    (req_q && ack_i) |=> !req_q);
endmodule

// File: rtl/vcmap_seq.sv
module vcmap_seq #(
  parameter int          NCH        = vcmap_pkg::NUM_CH,
  parameter int          TCW        = vcmap_pkg::TC_W,
  parameter int          AW         = 16,
  parameter int          DW         = 32,
  parameter int          POLL_LIMIT = 16,
  parameter logic [15:0] CFG_ADDR   = 16'h0040,
  parameter logic [15:0] CAP_ADDR   = 16'h0008,
  parameter logic [15:0] CH_BASE    = 16'h0100,
  parameter logic [15:0] CH_STRIDE  = 16'h0010,
  parameter logic [15:0] STS_OFS    = 16'h0008
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [NCH*TCW-1:0] tc_map_i,
  input  logic [NCH-1:0]     ch_act_i,
  output logic [NCH*TCW-1:0] maps_o,
  output logic [NCH-1:0]     act_o,
  input  logic               map_ok_i,
  input  logic [NCH*32-1:0]  words_i,
  output logic               go_o,
  output logic               we_o,
  output logic [AW-1:0]      addr_o,
  output logic [DW-1:0]      wdata_o,
  input  logic               fin_i,
  input  logic [DW-1:0]      rdata_i,
  output logic               done_o,
  output logic               err_o
);
  import vcmap_pkg::*;

  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int PCW = $clog2(POLL_LIMIT + 1);
  localparam logic [CHW-1:0] LAST_CH   = CHW'(NCH - 1);
  localparam logic [PCW-1:0] LAST_POLL = PCW'(POLL_LIMIT - 1);

  seq_state_t         state_q;
  logic [CHW-1:0]     ch_q;
  logic [PCW-1:0]     poll_q;
  logic               wait_q, done_q, err_q, locked_q;
  logic [NCH*TCW-1:0] maps_q;
  logic [NCH-1:0]     act_q;
  logic [DW-1:0]      cfg_q, cap_q, cfg_prog;
  logic [AW-1:0]      ch_addr;
  logic               bus_state;

  assign maps_o = maps_q;
  assign act_o  = act_q;

  // Programmed configuration value: field set, private-channel bits (R3)
  always_comb begin
    cfg_prog = cfg_q;
    cfg_prog[CFG_FLD_LSB +: CFG_FLD_W] = CFG_FLD_W'(CFG_FLD_VAL);
    if (act_q[PRIV_CH]) begin
      cfg_prog[CFG_PRIV_A] = 1'b1;
      cfg_prog[CFG_PRIV_B] = 1'b1;
    end
  end

  assign ch_addr = AW'(CH_BASE) + AW'(ch_q) * AW'(CH_STRIDE);

  always_comb begin
    bus_state = 1'b1;
    we_o      = 1'b0;
    addr_o    = '0;
    wdata_o   = '0;
    unique case (state_q)
      ST_CFG_RD: addr_o = AW'(CFG_ADDR);
      ST_CFG_WR: begin
        we_o = 1'b1; addr_o = AW'(CFG_ADDR); wdata_o = cfg_prog;
      end
      ST_CTL_WR: begin
        we_o = 1'b1; addr_o = ch_addr; wdata_o = words_i[ch_q*32 +: 32];
      end
      ST_CAP_RD: addr_o = AW'(CAP_ADDR);
      ST_CAP_WR: begin
        we_o = 1'b1; addr_o = AW'(CAP_ADDR);
        wdata_o = cap_q;
        wdata_o[CAP_CNT_W-1:0] = CAP_CNT_W'(act_q[SEC_CH]);
      end
      ST_POLL: addr_o = ch_addr + AW'(STS_OFS);
      ST_LOCK: begin
        we_o = 1'b1; addr_o = AW'(CFG_ADDR);
        wdata_o = cfg_prog;
        wdata_o[CFG_LOCK_BIT] = 1'b1;
      end
      default: bus_state = 1'b0;
    endcase
  end

  assign go_o = bus_state && !wait_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      ch_q     <= '0;
      poll_q   <= '0;
      wait_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      locked_q <= 1'b0;
      maps_q   <= '0;
      act_q    <= '0;
      cfg_q    <= '0;
      cap_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_o) wait_q <= 1'b1;
      if (fin_i) wait_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (locked_q) begin
              done_q <= 1'b1;                 // R9: no accesses once locked
            end else begin
              err_q   <= 1'b0;
              maps_q  <= tc_map_i;
              act_q   <= ch_act_i;
              state_q <= ST_CHECK;
            end
          end
        end
        ST_CHECK: begin
          if (map_ok_i) begin
            state_q <= ST_CFG_RD;
          end else begin
            err_q   <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_CFG_RD: if (fin_i) begin
          cfg_q   <= rdata_i;
          state_q <= ST_CFG_WR;
        end
        ST_CFG_WR: if (fin_i) begin
          ch_q    <= '0;
          state_q <= ST_CTL_WR;
        end
        ST_CTL_WR: if (fin_i) begin
          if (ch_q == LAST_CH) begin
            ch_q    <= '0;
            state_q <= ST_CAP_RD;
          end else begin
            ch_q <= ch_q + 1'b1;
          end
        end
        ST_CAP_RD: if (fin_i) begin
          cap_q   <= rdata_i;
          state_q <= ST_CAP_WR;
        end
        ST_CAP_WR: if (fin_i) begin
          ch_q    <= '0;
          poll_q  <= '0;
          state_q <= ST_POLL;
        end
        ST_POLL: if (fin_i) begin
          if (!rdata_i[STS_PEND_BIT]) begin
            poll_q <= '0;
            if (ch_q == LAST_CH) state_q <= ST_LOCK;
            else ch_q <= ch_q + 1'b1;
          end else if (poll_q == LAST_POLL) begin
            err_q   <= 1'b1;                  // R7: negotiation timeout
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            poll_q <= poll_q + 1'b1;
          end
        end
        ST_LOCK: if (fin_i) begin
          locked_q <= 1'b1;
          done_q   <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (state_q == ST_IDLE && !wait_q));

  assert_ctl_needs_map_R2: assert property (@(posedge clk) disable iff (rst)
    (go_o && state_q == ST_CTL_WR) |-> map_ok_i);

  assert_locked_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    locked_q |-> !go_o);

  assert_poll_bound_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_POLL) |-> (poll_q <= LAST_POLL));

  assert_lock_after_poll_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_q) |-> $past(state_q == ST_LOCK));
endmodule

// File: rtl/vcmap_prog.sv
module vcmap_prog #(
  parameter int          POLL_LIMIT = 16,
  parameter int          AW         = 16,
  parameter int          DW         = 32,
  parameter logic [vcmap_pkg::NUM_CH*vcmap_pkg::ID_W-1:0] CH_IDS = {3'd7, 3'd2, 3'd1, 3'd0},
  parameter logic [15:0] CFG_ADDR   = 16'h0040,
  parameter logic [15:0] CAP_ADDR   = 16'h0008,
  parameter logic [15:0] CH_BASE    = 16'h0100,
  parameter logic [15:0] CH_STRIDE  = 16'h0010,
  parameter logic [15:0] STS_OFS    = 16'h0008
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [31:0]   tc_map_i,
  input  logic [3:0]    ch_act_i,
  output logic          done_o,
  output logic          err_o,
  output logic          reg_req_o,
  output logic          reg_we_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  input  logic [DW-1:0] reg_rdata_i,
  input  logic          reg_ack_i
);
  import vcmap_pkg::*;

  logic [NUM_CH*TC_W-1:0] maps;
  logic [NUM_CH-1:0]      act;
  logic                   map_ok;
  logic [NUM_CH*32-1:0]   words;
  logic                   go, we, fin;
  logic [AW-1:0]          addr;
  logic [DW-1:0]          wdata, rdata;

  vcmap_check #(
    .NCH (NUM_CH), .TCW (TC_W), .IDW (ID_W), .IDS (CH_IDS)
  ) check_i (
    .maps_i  (maps),
    .act_i   (act),
    .ok_o    (map_ok),
    .words_o (words)
  );

  vcmap_seq #(
    .NCH (NUM_CH), .TCW (TC_W), .AW (AW), .DW (DW),
    .POLL_LIMIT (POLL_LIMIT), .CFG_ADDR (CFG_ADDR), .CAP_ADDR (CAP_ADDR),
    .CH_BASE (CH_BASE), .CH_STRIDE (CH_STRIDE), .STS_OFS (STS_OFS)
  ) seq_i (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .tc_map_i (tc_map_i),
    .ch_act_i (ch_act_i),
    .maps_o   (maps),
    .act_o    (act),
    .map_ok_i (map_ok),
    .words_i  (words),
    .go_o     (go),
    .we_o     (we),
    .addr_o   (addr),
    .wdata_o  (wdata),
    .fin_i    (fin),
    .rdata_i  (rdata),
    .done_o   (done_o),
    .err_o    (err_o)
  );

  vcmap_bus #(.AW (AW), .DW (DW)) bus_i (
    .clk     (clk),
    .rst     (rst),
    .go_i    (go),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .fin_o   (fin),
    .rdata_o (rdata),
    .req_o   (reg_req_o),
    .we_o    (reg_we_o),
    .addr_o  (reg_addr_o),
    .wdata_o (reg_wdata_o),
    .rdata_i (reg_rdata_i),
    .ack_i   (reg_ack_i)
  );
endmodule

// File: tb/vcmap_prog_tb.sv
`timescale 1ns/1ps
module vcmap_prog_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] tc_map_i = '0;
  logic [3:0]  ch_act_i = '0;
  logic        done_o, err_o, reg_req_o, reg_we_o, reg_ack_i;
  logic [15:0] reg_addr_o;
  logic [31:0] reg_wdata_o, reg_rdata_i;

  always #2 clk = ~clk;

  vcmap_prog dut_i (
    .clk (clk), .rst (rst), .start_i (start_i), .tc_map_i (tc_map_i),
    .ch_act_i (ch_act_i), .done_o (done_o), .err_o (err_o),
    .reg_req_o (reg_req_o), .reg_we_o (reg_we_o), .reg_addr_o (reg_addr_o),
    .reg_wdata_o (reg_wdata_o), .reg_rdata_i (reg_rdata_i), .reg_ack_i (reg_ack_i)
  );

  localparam logic [31:0] CFG_INIT = 32'h00F0_0005;
  localparam logic [31:0] CAP_INIT = 32'h0000_00F5;

  // Register slave model
  logic [31:0] cfg_r, cap_r;
  logic [31:0] ctl_r [4];
  int          pend_left [4];
  int          pend_cfg [4];
  int          sts_cnt [4];
  int          wr_cnt, rd_cnt, last_ctl, last_sts;
  logic        ctl_order_bad, sts_order_bad, lock_seen, after_lock_bad;

  always @(posedge clk) begin
    if (rst) begin
      reg_ack_i <= 1'b0; reg_rdata_i <= '0;
      cfg_r <= CFG_INIT; cap_r <= CAP_INIT;
      wr_cnt <= 0; rd_cnt <= 0; last_ctl <= -1; last_sts <= -1;
      ctl_order_bad <= 1'b0; sts_order_bad <= 1'b0;
      lock_seen <= 1'b0; after_lock_bad <= 1'b0;
      for (int c = 0; c < 4; c++) begin
        ctl_r[c] <= '0; pend_left[c] <= pend_cfg[c]; sts_cnt[c] <= 0;
      end
    end else if (reg_req_o && !reg_ack_i) begin
      reg_ack_i <= 1'b1;
      if (lock_seen) after_lock_bad <= 1'b1;
      if (reg_we_o) begin
        wr_cnt <= wr_cnt + 1;
        if (reg_addr_o == 16'h0040) begin
          cfg_r <= reg_wdata_o;
          if (reg_wdata_o[31]) lock_seen <= 1'b1;
        end
        if (reg_addr_o == 16'h0008) cap_r <= reg_wdata_o;
        for (int c = 0; c < 4; c++)
          if (reg_addr_o == 16'h0100 + 16'(c) * 16'h0010) begin
            ctl_r[c] <= reg_wdata_o;
            if (c < last_ctl) ctl_order_bad <= 1'b1;
            last_ctl <= c;
          end
      end else begin
        rd_cnt <= rd_cnt + 1;
        reg_rdata_i <= '0;
        if (reg_addr_o == 16'h0040) reg_rdata_i <= cfg_r;
        if (reg_addr_o == 16'h0008) reg_rdata_i <= cap_r;
        for (int c = 0; c < 4; c++)
          if (reg_addr_o == 16'h0108 + 16'(c) * 16'h0010) begin
            sts_cnt[c] <= sts_cnt[c] + 1;
            if (c < last_sts) sts_order_bad <= 1'b1;
            last_sts <= c;
            if (pend_left[c] > 0) begin
              reg_rdata_i <= 32'h0000_0002;
              pend_left[c] <= pend_left[c] - 1;
            end
          end
      end
    end else begin
      reg_ack_i <= 1'b0;
    end
  end

  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] maps;
    logic [3:0]  act;
    logic [4:0]  p0, p1, p2, p3;
    logic        exp_err;
    logic        map_bad;
    logic [3:0]  exp_wr;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{32'h8004_0279, 4'hF, 5'd0, 5'd0, 5'd0,  5'd0, 1'b0, 1'b0, 4'd7},
    '{32'h8004_0279, 4'hF, 5'd3, 5'd1, 5'd5,  5'd2, 1'b0, 1'b0, 4'd7},
    '{32'h8004_027D, 4'hB, 5'd0, 5'd2, 5'd0,  5'd1, 1'b0, 1'b0, 4'd7},
    '{32'h8004_027B, 4'hD, 5'd1, 5'd0, 5'd0,  5'd0, 1'b0, 1'b0, 4'd7},
    '{32'h8004_027B, 4'hF, 5'd0, 5'd0, 5'd0,  5'd0, 1'b1, 1'b1, 4'd0},
    '{32'h8004_0278, 4'hF, 5'd0, 5'd0, 5'd0,  5'd0, 1'b1, 1'b1, 4'd0},
    '{32'h8004_0279, 4'hF, 5'd1, 5'd0, 5'd20, 5'd0, 1'b1, 1'b0, 4'd6}
  };

  localparam logic [2:0] IDS [4] = '{3'd0, 3'd1, 3'd2, 3'd7};

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_start(output bit got, output int wait_cyc);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    got = 0; wait_cyc = 0;
    while (!got && wait_cyc < 3000) begin
      if (done_o) got = 1;
      else begin @(negedge clk); wait_cyc++; end
    end
  endtask

  bit got;
  int wc;

  initial begin
    for (int c = 0; c < 4; c++) pend_cfg[c] = 0;
    do_reset();
    // R10: reset state
    chk(done_o == 0 && err_o == 0 && reg_req_o == 0, "R10 reset outputs",
        {29'b0, done_o, err_o, reg_req_o}, 32'h0);

    for (int v = 0; v < 7; v++) begin
      vec_t e;
      logic [31:0] exp_cfg, exp_cap, exp_w;
      e = VECS[v];
      pend_cfg[0] = int'(e.p0); pend_cfg[1] = int'(e.p1);
      pend_cfg[2] = int'(e.p2); pend_cfg[3] = int'(e.p3);
      tc_map_i = e.maps; ch_act_i = e.act;
      do_reset();
      run_start(got, wc);
      chk(got, "R10 done reached", {31'b0, got}, 32'h1);
      chk(err_o == e.exp_err, e.map_bad ? "R2 map error" : "R7 error flag",
          {31'b0, err_o}, {31'b0, e.exp_err});
      @(negedge clk);
      chk(done_o == 0, "R10 done single cycle", {31'b0, done_o}, 32'h0);
      chk(wr_cnt == int'(e.exp_wr), "R8 write count", wr_cnt, {28'b0, e.exp_wr});
      if (e.map_bad) begin
        chk(rd_cnt == 0, "R2 no reads on bad map", rd_cnt, 0);
      end else begin
        for (int c = 0; c < 4; c++) begin
          exp_w = {e.act[c], 4'b0, IDS[c], 16'b0, e.maps[8*c +: 8]};
          chk(ctl_r[c] == exp_w, "R1 control word", ctl_r[c], exp_w);
        end
        chk(!ctl_order_bad, "R4 control write order", {31'b0, ctl_order_bad}, 0);
        chk(!sts_order_bad, "R6 poll order", {31'b0, sts_order_bad}, 0);
        exp_cap = (CAP_INIT & ~32'h7) | {31'b0, e.act[1]};
        chk(cap_r == exp_cap, "R5 capability count", cap_r, exp_cap);
        exp_cfg = (CFG_INIT & ~32'h00F0_0000) | 32'h0020_0000
                | (e.act[2] ? 32'h000A_0000 : 32'h0);
        if (!e.exp_err) begin
          exp_cfg |= 32'h8000_0000;
          chk(cfg_r == exp_cfg, "R8 cfg locked", cfg_r, exp_cfg);
          chk(!after_lock_bad, "R8 lock is last access", {31'b0, after_lock_bad}, 0);
          for (int c = 0; c < 4; c++)
            chk(sts_cnt[c] == pend_cfg[c] + 1, "R6 poll reads", sts_cnt[c], pend_cfg[c] + 1);
        end else begin
          chk(cfg_r == exp_cfg, "R7 no lock on timeout", cfg_r, exp_cfg);
          chk(sts_cnt[2] == 16, "R7 poll limit reads", sts_cnt[2], 16);
          chk(sts_cnt[3] == 0, "R7 polling stopped", sts_cnt[3], 0);
          // R3 checked here too: private bits set, field = 2
          chk(cfg_r[23:17] == 7'b0010101, "R3 cfg field", {25'b0, cfg_r[23:17]}, 32'h15);
          repeat (3) @(negedge clk);
          chk(err_o == 1, "R10 err held", {31'b0, err_o}, 32'h1);
          tc_map_i = 32'h8004_0279; ch_act_i = 4'hF;
          start_i = 1'b1; @(negedge clk); start_i = 1'b0;
          @(negedge clk);
          chk(err_o == 0, "R10 err cleared by start", {31'b0, err_o}, 32'h0);
          repeat (200) @(negedge clk);
        end
      end
    end

    // R9: start after lock makes no accesses
    for (int c = 0; c < 4; c++) pend_cfg[c] = 0;
    tc_map_i = 32'h8004_0279; ch_act_i = 4'hF;
    do_reset();
    run_start(got, wc);
    begin
      int w0, r0;
      w0 = wr_cnt; r0 = rd_cnt;
      @(negedge clk);
      run_start(got, wc);
      chk(got && wc < 3, "R9 done while locked", wc, 0);
      repeat (20) @(negedge clk);
      chk(wr_cnt == w0 && rd_cnt == r0, "R9 no access while locked",
          wr_cnt + rd_cnt, w0 + r0);
      chk(err_o == 0, "R9 no error while locked", {31'b0, err_o}, 0);
    end

    // R3 without private channel: bits 19/17 stay clear
    tc_map_i = 32'h8004_027D; ch_act_i = 4'hB;
    do_reset();
    run_start(got, wc);
    chk(cfg_r[19] == 0 && cfg_r[17] == 0 && cfg_r[23:20] == 4'd2 && cfg_r[2:0] == 3'd5,
        "R3 cfg without private", cfg_r, 32'h8020_0005);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule